// File: doc/BRIEF.md
# Dual-Port Mailbox Bypass Registers

This block holds two 36-bit mail registers that let a word travel between two ports without passing through the pair of opposite-direction FIFOs sitting beside it. Port A deposits a word into mail1 and port B collects it. Port B deposits a word into mail2 and port A collects it. Each register has an active-low occupancy flag, registered in the writer's clock domain. While the flag is low, further deposits are refused. The flag returns high once the far port has read the word.

Each port has a chip select, a write/read direction, an enable and a mailbox select. On a read, the select chooses between the opposite mail register and the FIFO output word presented at the port. The result is registered into the port's data output. The two clocks are unrelated. Set and clear events cross between them as toggles through multi-stage synchronizers. Each FIFO's reset (master or partial) also returns the mailbox on that path to its empty state.

Top module: `mbx_bypass`

## Requirements
- R1: A port A cycle with a_cs_n=0, a_wr=1, a_en=1 and a_mbx=1, while mbf1_n is high, loads a_din into mail1 and drives mbf1_n low from that clk_a edge. Port B does the same for mail2 and mbf2_n.
- R2: While a mailbox flag is low, mailbox writes to it are refused, and the stored word keeps its value.
- R3: After a port B mailbox read of a full mail1, mbf1_n stays low for at least the next clk_a edge. It returns high within SYNC_STAGES+2 clk_a edges. It does not rise without such a read.
- R4: While fifo1_rst_n is low, mbf1_n is high, mail1 is zero and b_dout is zero. fifo2_rst_n does the same for mbf2_n, mail2 and a_dout. Neither reset affects the other path.
- R5: A read (cs_n=0, wr=0, en=1) with the mailbox select high loads the opposite mail register into the port's dout on that edge.
- R6: A read with the mailbox select low loads the port's FIFO output word (a_fifo_q or b_fifo_q) into dout on that edge.
- R7: A mailbox read while that mailbox holds no mail returns its stale contents and leaves the flag unchanged. It does not consume a word written afterwards.
- R8: dout holds its value on every edge without an active read.
- R9: A write cycle with the mailbox select low, or any cycle with cs_n high or en low, leaves the flags and mail registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| fifo1_rst_n | input | 1 | Active-low reset of the A-to-B path (mail1, mbf1_n, b_dout) |
| fifo2_rst_n | input | 1 | Active-low reset of the B-to-A path (mail2, mbf2_n, a_dout) |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A enable, active high |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_fifo_q | input | W | Output word of the B-to-A FIFO |
| a_dout | output | W | Port A registered read data |
| mbf1_n | output | 1 | mail1 occupancy flag, low when full (clk_a domain) |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_en | input | 1 | Port B enable, active high |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | W | Port B write data |
| b_fifo_q | input | W | Output word of the A-to-B FIFO |
| b_dout | output | W | Port B registered read data |
| mbf2_n | output | 1 | mail2 occupancy flag, low when full (clk_b domain) |

## Verification
Read data and the writer's own flag are due one edge after the cycle that causes them, so the bench samples them on the falling edge that follows. Handoff across the clocks takes up to SYNC_STAGES+2 edges of the receiving clock. The bench checks that the writer's flag is still low at the first falling edge after the far read, then checks it high five edges later. Every random operation is followed by a settle window of eight port B and two port A cycles before the next one starts. That way the reference model never has to predict a handoff still in flight.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Port-cycle decoding shared by both ports.
  function automatic logic f_mb_write(input logic cs_n, input logic wr,
                                      input logic en, input logic sel);
    return !cs_n && wr && en && sel;
  endfunction

  function automatic logic f_port_read(input logic cs_n, input logic wr,
                                       input logic en);
    return !cs_n && !wr && en;
  endfunction

  // A toggle crossing is seen as an event when the last two stages differ.
  function automatic logic f_tog_event(input logic newer, input logic older);
    return newer ^ older;
  endfunction
endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic evt
);
  import mbx_pkg::*;

  // STAGES synchronizer flops followed by one history flop.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tog_in};
  end

  assign evt = f_tog_event(chain[STAGES-1], chain[STAGES]);
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int W      = 36,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_try,
  input  logic [W-1:0] wdata,
  input  logic         rd_try,
  output logic [W-1:0] mail_q,
  output logic         full_n,
  output logic         clr_evt
);
  // Writer domain state
  logic w_full, w_tog;
  // Reader domain state
  logic r_full, r_tog;
  logic set_evt;
  logic wr_fire, rd_fire;

  assign wr_fire = wr_try && !w_full;
  assign rd_fire = rd_try && r_full;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      w_full <= 1'b0;
      w_tog  <= 1'b0;
      mail_q <= '0;
    end else if (wr_fire) begin
      w_full <= 1'b1;
      w_tog  <= ~w_tog;
      mail_q <= wdata;
    end else if (clr_evt) begin
      w_full <= 1'b0;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      r_full <= 1'b0;
      r_tog  <= 1'b0;
    end else if (rd_fire) begin
      r_full <= 1'b0;
      r_tog  <= ~r_tog;
    end else if (set_evt) begin
      r_full <= 1'b1;
    end
  end

  mbx_tog_sync #(.STAGES(STAGES)) u_to_reader (
    .clk(rclk), .rst_n(rst_n), .tog_in(w_tog), .evt(set_evt)
  );

  mbx_tog_sync #(.STAGES(STAGES)) u_to_writer (
    .clk(wclk), .rst_n(rst_n), .tog_in(r_tog), .evt(clr_evt)
  );

  assign full_n = ~w_full;
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  logic         sel_mail,
  input  logic [W-1:0] mail,
  input  logic [W-1:0] fifo_q,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= '0;
    else if (rd_en) dout <= sel_mail ? mail : fifo_q;
  end
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass #(
  parameter int W           = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         fifo1_rst_n,
  input  logic         fifo2_rst_n,
  input  logic         a_cs_n,
  input  logic         a_wr,
  input  logic         a_en,
  input  logic         a_mbx,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_dout,
  output logic         mbf1_n,
  input  logic         b_cs_n,
  input  logic         b_wr,
  input  logic         b_en,
  input  logic         b_mbx,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_dout,
  output logic         mbf2_n
);
  import mbx_pkg::*;

  // Named port events
  logic a_mb_wr, a_rd, a_mb_rd;
  logic b_mb_wr, b_rd, b_mb_rd;
  logic [W-1:0] mail1_q, mail2_q;
  logic m1_clr_evt, m2_clr_evt;

  assign a_mb_wr = f_mb_write(a_cs_n, a_wr, a_en, a_mbx);
  assign a_rd    = f_port_read(a_cs_n, a_wr, a_en);
  assign a_mb_rd = a_rd && a_mbx;
  assign b_mb_wr = f_mb_write(b_cs_n, b_wr, b_en, b_mbx);
  assign b_rd    = f_port_read(b_cs_n, b_wr, b_en);
  assign b_mb_rd = b_rd && b_mbx;

  // A -> B mailbox
  mbx_channel #(.W(W), .STAGES(SYNC_STAGES)) u_ch1 (
    .wclk(clk_a), .rclk(clk_b), .rst_n(fifo1_rst_n),
    .wr_try(a_mb_wr), .wdata(a_din), .rd_try(b_mb_rd),
    .mail_q(mail1_q), .full_n(mbf1_n), .clr_evt(m1_clr_evt)
  );

  // B -> A mailbox
  mbx_channel #(.W(W), .STAGES(SYNC_STAGES)) u_ch2 (
    .wclk(clk_b), .rclk(clk_a), .rst_n(fifo2_rst_n),
    .wr_try(b_mb_wr), .wdata(b_din), .rd_try(a_mb_rd),
    .mail_q(mail2_q), .full_n(mbf2_n), .clr_evt(m2_clr_evt)
  );

  mbx_rd_port #(.W(W)) u_rd_a (
    .clk(clk_a), .rst_n(fifo2_rst_n), .rd_en(a_rd), .sel_mail(a_mbx),
    .mail(mail2_q), .fifo_q(a_fifo_q), .dout(a_dout)
  );

  mbx_rd_port #(.W(W)) u_rd_b (
    .clk(clk_b), .rst_n(fifo1_rst_n), .rd_en(b_rd), .sel_mail(b_mbx),
    .mail(mail1_q), .fifo_q(b_fifo_q), .dout(b_dout)
  );
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         fifo1_rst_n,
  input logic         fifo2_rst_n,
  input logic         a_mb_wr,
  input logic         b_mb_wr,
  input logic         a_rd,
  input logic         b_rd,
  input logic         a_mbx,
  input logic         b_mbx,
  input logic [W-1:0] a_din,
  input logic [W-1:0] b_din,
  input logic         mbf1_n,
  input logic         mbf2_n,
  input logic [W-1:0] mail1_q,
  input logic [W-1:0] mail2_q,
  input logic         m1_clr_evt,
  input logic         m2_clr_evt,
  input logic [W-1:0] a_fifo_q,
  input logic [W-1:0] b_fifo_q,
  input logic [W-1:0] a_dout,
  input logic [W-1:0] b_dout
);
  p_wr_sets_flag_r1: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
    a_mb_wr && mbf1_n |=> !mbf1_n && mail1_q == $past(a_din));
  p_wr_sets_flag2_r1: assert property (@(posedge clk_b) disable iff (!fifo2_rst_n)
    b_mb_wr && mbf2_n |=> !mbf2_n && mail2_q == $past(b_din));

  p_blocked_wr_r2: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
    a_mb_wr && !mbf1_n |=> $stable(mail1_q));
  p_blocked_wr2_r2: assert property (@(posedge clk_b) disable iff (!fifo2_rst_n)
    b_mb_wr && !mbf2_n |=> $stable(mail2_q));

  p_flag_held_r3: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
    !mbf1_n && !m1_clr_evt |=> !mbf1_n);
  p_flag_held2_r3: assert property (@(posedge clk_b) disable iff (!fifo2_rst_n)
    !mbf2_n && !m2_clr_evt |=> !mbf2_n);

  p_rst_flag_r4: assert property (@(posedge clk_a)
    !fifo1_rst_n |-> mbf1_n && mail1_q == '0);
  p_rst_dout_r4: assert property (@(posedge clk_b)
    !fifo1_rst_n |-> b_dout == '0);

  p_mbx_rd_r5: assert property (@(posedge clk_b) disable iff (!fifo1_rst_n)
    b_rd && b_mbx |=> b_dout == $past(mail1_q));
  p_mbx_rd2_r5: assert property (@(posedge clk_a) disable iff (!fifo2_rst_n)
    a_rd && a_mbx |=> a_dout == $past(mail2_q));

  p_fifo_rd_r6: assert property (@(posedge clk_b) disable iff (!fifo1_rst_n)
    b_rd && !b_mbx |=> b_dout == $past(b_fifo_q));
  p_fifo_rd2_r6: assert property (@(posedge clk_a) disable iff (!fifo2_rst_n)
    a_rd && !a_mbx |=> a_dout == $past(a_fifo_q));

  p_idle_hold_r8: assert property (@(posedge clk_b) disable iff (!fifo1_rst_n)
    !b_rd |=> $stable(b_dout));
  p_idle_hold2_r8: assert property (@(posedge clk_a) disable iff (!fifo2_rst_n)
    !a_rd |=> $stable(a_dout));

  p_no_write_r9: assert property (@(posedge clk_a) disable iff (!fifo1_rst_n)
    !a_mb_wr |=> $stable(mail1_q));
endmodule

bind mbx_bypass mbx_bypass_chk #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b),
  .fifo1_rst_n(fifo1_rst_n), .fifo2_rst_n(fifo2_rst_n),
  .a_mb_wr(a_mb_wr), .b_mb_wr(b_mb_wr), .a_rd(a_rd), .b_rd(b_rd),
  .a_mbx(a_mbx), .b_mbx(b_mbx), .a_din(a_din), .b_din(b_din),
  .mbf1_n(mbf1_n), .mbf2_n(mbf2_n), .mail1_q(mail1_q), .mail2_q(mail2_q),
  .m1_clr_evt(m1_clr_evt), .m2_clr_evt(m2_clr_evt),
  .a_fifo_q(a_fifo_q), .b_fifo_q(b_fifo_q), .a_dout(a_dout), .b_dout(b_dout)
);

// File: tb/mbx_bypass_bench.sv
module mbx_bypass_bench;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic fifo1_rst_n = 1'b0, fifo2_rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
  logic b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0, b_mbx = 1'b0;
  logic [W-1:0] a_din = '0, b_din = '0, a_fifo_q = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic mbf1_n, mbf2_n;

  int n_tests = 0, n_fail = 0;

  // Reference model
  bit           m1_full = 0, m2_full = 0;
  logic [W-1:0] m1_val = '0, m2_val = '0;
  logic [W-1:0] a_last = '0, b_last = '0;

  always #4 clk_a = ~clk_a;   // 125 MHz
  always #5 clk_b = ~clk_b;   // unrelated port B clock

  mbx_bypass #(.W(W), .SYNC_STAGES(2)) u_mbx_bypass (
    .clk_a(clk_a), .clk_b(clk_b), .fifo1_rst_n(fifo1_rst_n), .fifo2_rst_n(fifo2_rst_n),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbx(a_mbx), .a_din(a_din),
    .a_fifo_q(a_fifo_q), .a_dout(a_dout), .mbf1_n(mbf1_n),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mbx(b_mbx), .b_din(b_din),
    .b_fifo_q(b_fifo_q), .b_dout(b_dout), .mbf2_n(mbf2_n)
  );

  function automatic logic exp_flag(input bit full);
    return full ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [W-1:0] exp_pick(input logic sel, input logic [W-1:0] mail,
                                            input logic [W-1:0] fifo);
    if (sel) return mail;
    return fifo;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom_range(15, 0), $urandom()};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_cycle(input logic cs_n, input logic wr, input logic en,
                         input logic sel, input logic [W-1:0] din);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = sel; a_din = din;
    @(negedge clk_a);
    a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b0;
  endtask

  task automatic b_cycle(input logic cs_n, input logic wr, input logic en,
                         input logic sel, input logic [W-1:0] din);
    @(negedge clk_b);
    b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbx = sel; b_din = din;
    @(negedge clk_b);
    b_cs_n = 1'b1; b_wr = 1'b0; b_en = 1'b0; b_mbx = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_b);
    repeat (2) @(negedge clk_a);
  endtask

  task automatic a_write_mb(input logic [W-1:0] d);
    a_cycle(1'b0, 1'b1, 1'b1, 1'b1, d);
    if (!m1_full) begin m1_val = d; m1_full = 1; end
    chk("R1/R2 mbf1_n after A mailbox write", mbf1_n, exp_flag(m1_full));
    settle();
  endtask

  task automatic b_write_mb(input logic [W-1:0] d);
    b_cycle(1'b0, 1'b1, 1'b1, 1'b1, d);
    if (!m2_full) begin m2_val = d; m2_full = 1; end
    chk("R1/R2 mbf2_n after B mailbox write", mbf2_n, exp_flag(m2_full));
    settle();
  endtask

  task automatic b_read(input logic sel);
    b_fifo_q = rnd_word();
    b_cycle(1'b0, 1'b0, 1'b1, sel, '0);
    b_last = exp_pick(sel, m1_val, b_fifo_q);
    chk(sel ? "R5/R7 b_dout mailbox read" : "R6 b_dout fifo read", b_dout, b_last);
    if (sel) m1_full = 0;
    settle();
    chk("R3/R7 mbf1_n after B read", mbf1_n, exp_flag(m1_full));
  endtask

  task automatic a_read(input logic sel);
    a_fifo_q = rnd_word();
    a_cycle(1'b0, 1'b0, 1'b1, sel, '0);
    a_last = exp_pick(sel, m2_val, a_fifo_q);
    chk(sel ? "R5/R7 a_dout mailbox read" : "R6 a_dout fifo read", a_dout, a_last);
    if (sel) m2_full = 0;
    settle();
    chk("R3/R7 mbf2_n after A read", mbf2_n, exp_flag(m2_full));
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk_a);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk_b);
    // R4 reset state
    chk("R4 mbf1_n in reset", mbf1_n, 1'b1);
    chk("R4 mbf2_n in reset", mbf2_n, 1'b1);
    chk("R4 a_dout in reset", a_dout, '0);
    chk("R4 b_dout in reset", b_dout, '0);
    @(negedge clk_a); fifo1_rst_n = 1'b1; fifo2_rst_n = 1'b1;
    settle();

    // R1, R2: fill, then blocked write keeps first word
    a_write_mb(36'h1_2345_6789);
    a_write_mb(36'hF_0F0F_0F0F);
    // R3 timing of the flag return
    b_fifo_q = '0;
    b_cycle(1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk("R2/R5 b_dout keeps first word", b_dout, 36'h1_2345_6789);
    b_last = b_dout;
    chk("R3 mbf1_n still low right after read", mbf1_n, 1'b0);
    repeat (5) @(negedge clk_a);
    chk("R3 mbf1_n high after handoff", mbf1_n, 1'b1);
    m1_full = 0;
    settle();

    // R7: read of empty mailbox returns stale word, no phantom consumption
    b_read(1'b1);
    a_write_mb(36'hA_BCDE_F012);
    repeat (10) @(negedge clk_a);
    chk("R7 mbf1_n stays low after earlier empty read", mbf1_n, 1'b0);
    b_read(1'b1);

    // Channel 2 directed
    b_write_mb(36'h5_5555_AAAA);
    b_write_mb(36'h0_0000_0001);
    a_read(1'b1);
    a_read(1'b0);

    // R9: non-mailbox write and deselected cycles leave the flag
    a_cycle(1'b0, 1'b1, 1'b1, 1'b0, 36'h7_7777_7777);
    chk("R9 mbf1_n after fifo-side write", mbf1_n, 1'b1);
    a_cycle(1'b1, 1'b1, 1'b1, 1'b1, 36'h6_6666_6666);
    chk("R9 mbf1_n after deselected write", mbf1_n, 1'b1);
    chk("R8 a_dout holds without read", a_dout, a_last);
    settle();
    b_read(1'b1);
    chk("R9 mail1 unchanged by ignored writes", b_dout, 36'hA_BCDE_F012);

    // R4: reset of path 1 only
    a_write_mb(36'h3_3333_3333);
    b_write_mb(36'h4_4444_4444);
    b_read(1'b0);
    @(negedge clk_a); fifo1_rst_n = 1'b0;
    repeat (4) @(negedge clk_b);
    chk("R4 mbf1_n forced high", mbf1_n, 1'b1);
    chk("R4 b_dout cleared", b_dout, '0);
    chk("R4 mbf2_n unaffected", mbf2_n, 1'b0);
    @(negedge clk_a); fifo1_rst_n = 1'b1;
    m1_full = 0; m1_val = '0; b_last = '0;
    settle();
    b_read(1'b1);
    chk("R4 mail1 cleared by reset", b_dout, '0);

    // Random phase
    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(7, 0))
        0: a_write_mb(rnd_word());
        1: b_read(1'b1);
        2: b_write_mb(rnd_word());
        3: a_read(1'b1);
        4: b_read(1'b0);
        5: a_read(1'b0);
        6: begin
          b_cycle(1'b0, 1'b1, 1'b1, 1'b0, rnd_word());
          chk("R9 mbf2_n after fifo-side write", mbf2_n, exp_flag(m2_full));
          chk("R8 b_dout holds on write", b_dout, b_last);
          settle();
        end
        default: begin
          a_cycle(1'b0, 1'b0, 1'b0, 1'b1, '0);
          chk("R8 a_dout holds when en low", a_dout, a_last);
          chk("R9 mbf1_n when en low", mbf1_n, exp_flag(m1_full));
          settle();
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule